// File: doc/BRIEF.md
# Comparator Output Qualification Filter

This block is the digital back end of an analog comparator. The raw comparator bit has no timing relation to the system clock. It is resynchronized by a two-stage flop chain. It can then be inverted, and it passes through a programmable run-length filter. The filter moves its output to a new level only after its input has shown that level on a chosen number of consecutive clocks. The filtered level can be read as a status bit.

A small register port with a 2-bit word address holds three registers. The control word carries the filter length code, the polarity select, the reference-source select and the enable. The status word carries the filtered level. The DAC word carries a 10-bit threshold code. The block drives the enable, the source select and the DAC code to the analog side. It does not model the analog comparator, the DAC or the input multiplexer.

Register map (word addresses): 0 is the control word, 1 is the status word (read-only), 2 is the DAC code word, and 3 reads as zero. Writes land on the rising clock edge while `bus_wr_en` is high. Reads are combinational from `bus_addr`.

Top module: `cmpq_top`

## Requirements
- R1: After reset, every register reads 0x0000 and the outputs `ana_enable`, `ana_src_ext` and `dac_code` are 0.
- R2: The control word at address 0 uses these fields: bits 7:3 are the filter length code, bit 2 is the polarity select, bit 1 is the source select and bit 0 is the enable. Bits 15:8 ignore writes and read as 0. `ana_src_ext` follows bit 1 and `ana_enable` follows bit 0.
- R3: The DAC word at address 2 stores bits 9:0 and drives them on `dac_code`. Bits 15:10 read as 0.
- R4: The status word at address 1 returns the filtered level in bit 0 and zeros in bits 15:1. Writes to address 1 change nothing.
- R5: With length code 0, the filtered level follows the synchronized comparator level with no run requirement. A high pulse on `cmp_raw` that lasts W clocks gives a status high window of exactly W clocks. The status first reads high after the 2nd rising edge that follows the first sampling edge.
- R6: With length code n from 1 to 15, the filter input must show the same level on n+1 consecutive clocks before the filtered level may change. A pulse shorter than n+1 clocks is dropped. A longer pulse W appears as a status window of W clocks. The window opens n+2 edges after the first sampling edge.
- R7: Length codes 16 to 31 behave like code 15 and need a run of 16 clocks.
- R8: With the polarity bit set to 1, the inverse of the comparator level enters the filter. An idle-low comparator then gives status 1, and a high pulse on `cmp_raw` shows as a low window.
- R9: While the enable bit is 0, the synchronizer, the run counter and the filtered level are held at 0, so status reads 0. After the block is enabled again, the run count starts over from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_raw | input | 1 | Raw comparator output, asynchronous |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data (combinational) |
| ana_enable | output | 1 | Powers the comparator and DAC |
| ana_src_ext | output | 1 | Reference source select: 0 = internal DAC, 1 = external pin |
| dac_code | output | 10 | DAC threshold code |

## Verification
A run counter that saturates too early or restarts at the wrong time shows up directly in the status bit. A pulse that should be dropped gets through, or a status window opens one clock early or late. The pulse sweep catches this on the first pulse whose width lies next to the run length. A missing synchronizer stage or a stuck polarity bit moves the edge where status first changes, or leaves status at the wrong idle level, within a few clocks of the stimulus. A bad enable hold shows as a nonzero status while disabled, or as the wrong restart delay after the enable write.

// File: rtl/cmpq_pkg.sv
package cmpq_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 2;
    localparam int QSEL_W = 5;
    localparam int DAC_W  = 10;
    localparam int MAX_RUN = 16;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_DAC  = 2'd2;

    // Control word layout, msb first: length code, polarity, source, enable
    typedef struct packed {
        logic [QSEL_W-1:0] qsel;
        logic              inv;
        logic              src_ext;
        logic              en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/cmpq_regs.sv
module cmpq_regs
    import cmpq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              status_bit,
    output logic [DATA_W-1:0] rdata,
    output ctrl_t             ctrl,
    output logic [DAC_W-1:0]  dac
);
    typedef struct packed {
        ctrl_t             ctrl;
        logic [DAC_W-1:0]  dac;
    } regs_t;

    regs_t r_d, r_q;

    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata[DATA_W-1:CTRL_W];

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (addr)
                ADDR_CTRL: r_d.ctrl = ctrl_t'(wdata[CTRL_W-1:0]);
                ADDR_DAC:  r_d.dac  = wdata[DAC_W-1:0];
                default:   r_d      = r_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_CTRL: rdata[CTRL_W-1:0] = r_q.ctrl;
            ADDR_STAT: rdata[0]          = status_bit;
            ADDR_DAC:  rdata[DAC_W-1:0]  = r_q.dac;
            default:   rdata             = '0;
        endcase
    end

    assign ctrl = r_q.ctrl;
    assign dac  = r_q.dac;

    // R4: a write to the status address leaves both stored words alone
    a_r4_status_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_STAT) |=> $stable(r_q));
    // R2: a control write is stored as written, low byte only
    a_r2_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_CTRL) |=> (r_q.ctrl == $past(wdata[CTRL_W-1:0])));
endmodule

// File: rtl/cmpq_sync.sv
module cmpq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic raw_i,
    output logic sync_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!en_i) s_d.chain = '0;
        else       s_d.chain = {s_q.chain[STAGES-2:0], raw_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sync_o = s_q.chain[STAGES-1];

    // R9: disabled block clears its synchronizer on the next edge
    a_r9_sync_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (sync_o == 1'b0));
endmodule

// File: rtl/cmpq_qual.sv
module cmpq_qual #(
    parameter int QSEL_W  = 5,
    parameter int MAX_RUN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [QSEL_W-1:0] qsel_i,
    input  logic              in_i,
    output logic              out_o
);
    localparam int CNT_W = $clog2(MAX_RUN + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_RUN);

    typedef struct packed {
        logic             samp;
        logic [CNT_W-1:0] cnt;
        logic             out;
    } qual_t;

    qual_t q_d, q_q;
    logic [CNT_W-1:0] need;

    // Required run length: 1 for code 0, code+1 up to MAX_RUN, clipped above
    always_comb begin
        if (qsel_i == '0)
            need = CNT_W'(1);
        else if (qsel_i >= QSEL_W'(MAX_RUN - 1))
            need = CNT_MAX;
        else
            need = CNT_W'(qsel_i) + CNT_W'(1);
    end

    always_comb begin
        q_d = q_q;
        if (!en_i) begin
            q_d = '0;
        end else begin
            if (in_i != q_q.samp)   q_d.cnt = CNT_W'(1);
            else if (q_q.cnt == CNT_MAX) q_d.cnt = CNT_MAX;
            else                    q_d.cnt = q_q.cnt + CNT_W'(1);
            q_d.samp = in_i;
            if (q_d.cnt >= need) q_d.out = in_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign out_o = q_q.out;

    // R6: a new filtered level always equals the last held sample
    a_r6_change_matches_sample: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q_q.out) |-> (q_q.out == q_q.samp));
    // R7: run counter never passes the longest run
    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q_q.cnt <= CNT_MAX);
    // R9: disabled filter holds counter and output at zero
    a_r9_filter_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (q_q.out == 1'b0 && q_q.cnt == '0));
    // R5: code 0 copies the input through one register
    a_r5_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && qsel_i == '0) |=> (out_o == $past(in_i)));
endmodule

// File: rtl/cmpq_top.sv
module cmpq_top
    import cmpq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_raw,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              ana_enable,
    output logic              ana_src_ext,
    output logic [DAC_W-1:0]  dac_code
);
    ctrl_t ctrl;
    logic  sync_lvl;
    logic  pol_lvl;
    logic  filt_lvl;

    cmpq_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (bus_wr_en),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .status_bit (filt_lvl),
        .rdata      (bus_rdata),
        .ctrl       (ctrl),
        .dac        (dac_code)
    );

    cmpq_sync #(.STAGES(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (ctrl.en),
        .raw_i  (cmp_raw),
        .sync_o (sync_lvl)
    );

    assign pol_lvl = sync_lvl ^ ctrl.inv;

    cmpq_qual #(.QSEL_W(QSEL_W), .MAX_RUN(MAX_RUN)) u_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (ctrl.en),
        .qsel_i (ctrl.qsel),
        .in_i   (pol_lvl),
        .out_o  (filt_lvl)
    );

    assign ana_enable  = ctrl.en;
    assign ana_src_ext = ctrl.src_ext;

    // R4: status reads carry nothing above bit 0
    a_r4_status_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_STAT) |-> (bus_rdata[DATA_W-1:1] == '0));
    // R3: DAC reads carry nothing above the code
    a_r3_dac_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_DAC) |-> (bus_rdata[DATA_W-1:DAC_W] == '0));
    // R9: status is 0 whenever the block has been off for a clock
    a_r9_status_off: assert property (@(posedge clk) disable iff (!rst_n)
        !ana_enable |=> (!ana_enable || !filt_lvl || $past(ana_enable)) );
endmodule

// File: tb/sim_cmpq_top.sv
`timescale 1ns/1ps
module sim_cmpq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_raw = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        ana_enable, ana_src_ext;
    logic [9:0]  dac_code;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cmpq_top u0 (
        .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw),
        .bus_wr_en(bus_wr_en), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .ana_enable(ana_enable),
        .ana_src_ext(ana_src_ext), .dac_code(dac_code)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] cw(input int sel, input bit inv, input bit src, input bit en);
        return 16'((sel << 3) | (int'(inv) << 2) | (int'(src) << 1) | int'(en));
    endfunction

    // required run length from the length code (R5, R6, R7)
    function automatic int run_len(input int sel);
        if (sel == 0) return 1;
        if (sel >= 15) return 16;
        return sel + 1;
    endfunction

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Pulse cmp_raw high for w edges; track the status window at the ports
    task automatic pulse(input int w, input int sel, input bit inv, input string req);
        int first = -1;
        int active = 0;
        int need = run_len(sel);
        bit act_lvl = ~inv;
        @(negedge clk);
        bus_addr = 2'd1;
        cmp_raw = 1'b1;
        for (int i = 1; i <= w + need + 4; i++) begin
            @(posedge clk);
            #1;
            if (bus_rdata[0] == act_lvl) begin
                active++;
                if (first < 0) first = i;
            end
            if (i == w) begin
                @(negedge clk);
                cmp_raw = 1'b0;
            end
        end
        if (w >= need) begin
            check({req, " window width"}, active, w);
            check({req, " window start"}, first, need + 2);
        end else begin
            check({req, " short pulse dropped"}, active, 0);
        end
        idle(3);
    endtask

    logic [15:0] v;

    initial begin : wdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, v); check("R1 ctrl reset", v, 0);
        rd(2'd1, v); check("R1 status reset", v, 0);
        rd(2'd2, v); check("R1 dac reset", v, 0);
        rd(2'd3, v); check("R1 unmapped", v, 0);
        check("R1 outputs", {ana_enable, ana_src_ext, dac_code}, 0);

        // R2 control fields and reserved bits
        wr(2'd0, 16'hFFFA);
        rd(2'd0, v); check("R2 ctrl mask", v, 16'h00FA);
        check("R2 src/en pins", {ana_src_ext, ana_enable}, 2'b10);
        wr(2'd0, 16'h0001);
        check("R2 src/en pins b", {ana_src_ext, ana_enable}, 2'b01);

        // R3 DAC word
        wr(2'd2, 16'hFFFF);
        rd(2'd2, v); check("R3 dac mask", v, 16'h03FF);
        check("R3 dac pin", dac_code, 10'h3FF);
        wr(2'd2, 16'h0155);
        check("R3 dac pin b", dac_code, 10'h155);

        // R4 status write ignored
        wr(2'd1, 16'hFFFF);
        rd(2'd0, v); check("R4 ctrl after status write", v, 16'h0001);
        rd(2'd2, v); check("R4 dac after status write", v, 16'h0155);
        rd(2'd1, v); check("R4 status idle", v, 0);

        // R5, R6, R7: sweep every length code against pulse widths
        for (int sel = 0; sel < 32; sel++) begin
            wr(2'd0, cw(sel, 1'b0, 1'b0, 1'b1));
            idle(20);
            for (int w = 1; w <= 18; w++) begin
                if (sel == 0)       pulse(w, sel, 1'b0, "R5");
                else if (sel < 16)  pulse(w, sel, 1'b0, "R6");
                else                pulse(w, sel, 1'b0, "R7");
            end
        end

        // R8 inverted polarity
        for (int sel = 0; sel < 6; sel++) begin
            wr(2'd0, cw(sel * 3, 1'b1, 1'b0, 1'b1));
            idle(20);
            rd(2'd1, v); check("R8 idle level inverted", v, 1);
            for (int w = 1; w <= 18; w += 3) pulse(w, sel * 3, 1'b1, "R8");
        end

        // R9 disabled: status stays 0 whatever the input and polarity
        wr(2'd0, cw(3, 1'b1, 1'b0, 1'b0));
        cmp_raw = 1'b1;
        idle(10);
        rd(2'd1, v); check("R9 disabled inv=1 raw=1", v, 0);
        cmp_raw = 1'b0;
        idle(10);
        rd(2'd1, v); check("R9 disabled inv=1 raw=0", v, 0);
        check("R9 enable pin low", ana_enable, 0);

        // R9 restart: raw held high, enable with code 3 (run 4).
        // Commit edge 1, sync clear there, 2 sync stages, then a run of 4: first high at edge 4+3.
        wr(2'd0, cw(3, 1'b0, 1'b0, 1'b0));
        cmp_raw = 1'b1;
        idle(5);
        begin
            int first = -1;
            @(negedge clk);
            bus_wr_en = 1'b1; bus_addr = 2'd0; bus_wdata = cw(3, 1'b0, 1'b0, 1'b1);
            for (int i = 1; i <= 14; i++) begin
                @(posedge clk);
                #1;
                if (i == 1) begin
                    @(negedge clk);
                    bus_wr_en = 1'b0; bus_addr = 2'd1;
                    #1;
                end
                if (i > 1 && bus_rdata[0] && first < 0) first = i;
            end
            check("R9 restart delay", first, run_len(3) + 3);
        end
        cmp_raw = 1'b0;
        idle(5);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule